// File: doc/BRIEF.md
# Ping-pong nearest-neighbour scale pyramid

This block takes one greyscale frame over a valid/ready input stream, stores it, and then plays out a chain of images: the stored frame first, then repeatedly shrunk copies, each one 4/5 the width and height of the image before it. Resampling is nearest-neighbour. The source pixel of destination pixel (y, x) is (floor(5y/4), floor(5x/4)) in the previous image. It is found with an accumulator that steps in quarter-pixel units, so no divider is needed.

Two equal pixel stores take turns. While the current image streams out of one store, the next smaller image is built from it into the other store. After the consumer has taken the last pixel and pulses `img_done`, the roles swap and the next image plays out. The chain ends when the next image would be narrower or shorter than the detection window. The block then waits for a new frame.

Output stream rules: `out_valid` is raised while the current image has pixels left. A pixel moves on each rising clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the pixel and `out_last` are held and `out_valid` stays high. The input stream follows the same rules. `in_ready` is high only while a frame is being gathered.

Top module: `ds_scale_chain`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_level` is 0.
- R2: The block accepts exactly IMG_W×IMG_H pixels, in row-major order, on `in_valid && in_ready`. From the cycle after the last one until the chain ends, `in_ready` is 0.
- R3: Image level 0 reproduces the stored frame in row-major order, with `out_width`=IMG_W, `out_height`=IMG_H and `out_level`=0.
- R4: Image level k+1 has width floor(4w/5) and height floor(4h/5), where w×h is the size of level k. Its pixel (y, x) equals pixel (floor(5y/4), floor(5x/4)) of level k. `out_level` counts up by one per image.
- R5: `out_last` is 1 exactly on the final pixel of each image.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 with unchanged `out_pixel` and `out_last`.
- R7: The block moves to the next image only after the last pixel has been accepted and `img_done` has been seen high. An `img_done` pulse given before the last pixel is accepted is ignored. Between these two points, `out_valid` stays 0 and `out_level` stays unchanged.
- R8: An image is produced only if both its width and height are at least WIN. After the consumer finishes the final image, the block returns to the R1 state (`in_ready`=1, `out_level`=0) and gathers a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts frame pixels |
| in_pixel | input | PW | Input pixel, row-major |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts pixel |
| out_pixel | output | PW | Output pixel, row-major |
| out_last | output | 1 | Final pixel of the current image |
| out_width | output | clog2(IMG_W+1) | Width of the current image |
| out_height | output | clog2(IMG_H+1) | Height of the current image |
| out_level | output | clog2(IMG_H+1) | Index of the current image in the chain |
| img_done | input | 1 | Consumer finished the current image |

## Verification
The bench builds the block with a 20×12 frame and WIN=4, which gives a chain of five images (20×12, 16×9, 12×7, 9×5, 7×4). At that size the chain ends because the height limit is reached, and every level, including the last one and the return to loading, is covered in a few thousand cycles. Two frames go through: the first under a periodic stall on `out_ready`, the second with no stall. The small widths make the uneven source steps of 1 and 2 pixels, and odd image sizes, come up on every level.

// File: rtl/ds_scale_pkg.sv
package ds_scale_pkg;
  typedef enum logic {ST_LOAD = 1'b0, ST_RUN = 1'b1} ds_state_e;

  // size of the next pyramid level: floor(d * 4 / 5)
  function automatic logic [31:0] shrink_dim(input logic [31:0] d);
    return (d * 32'd4) / 32'd5;
  endfunction
endpackage

// File: rtl/ds_pix_mem.sv
module ds_pix_mem #(
  parameter int DEPTH = 16,
  parameter int PW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [PW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [PW-1:0] rb_data
);
  logic [PW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign ra_data = cells[ra_addr];
  assign rb_data = cells[rb_addr];
endmodule

// File: rtl/ds_resample.sv
module ds_resample #(
  parameter int XW = 6,
  parameter int YW = 5,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          active,
  input  logic [XW-1:0] src_w,
  input  logic [YW-1:0] src_h,
  input  logic [XW-1:0] dst_w,
  input  logic [YW-1:0] dst_h,
  output logic          we,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          fin
);
  localparam int QXW = XW + 3;
  localparam int QYW = YW + 3;
  localparam int PRW = AW + XW + 2;

  logic [XW-1:0]  dx;
  logic [YW-1:0]  dy;
  logic [QXW-1:0] qx;   // 5*dx in quarter pixels
  logic [QYW-1:0] qy;   // 5*dy in quarter pixels
  logic [AW-1:0]  wptr;
  logic           done_r;
  logic [XW:0]    sx;
  logic [YW:0]    sy;
  logic [PRW-1:0] prod;

  assign sx       = qx[QXW-1:2];
  assign sy       = qy[QYW-1:2];
  assign prod     = PRW'(sy) * PRW'(src_w) + PRW'(sx);
  assign src_addr = prod[AW-1:0];
  assign dst_addr = wptr;
  assign we       = active && !done_r;
  assign fin      = done_r || !active;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      dx <= '0; dy <= '0; qx <= '0; qy <= '0; wptr <= '0; done_r <= 1'b0;
    end else if (we) begin
      wptr <= wptr + AW'(1);
      if (dx == dst_w - XW'(1)) begin
        dx <= '0;
        qx <= '0;
        if (dy == dst_h - YW'(1)) done_r <= 1'b1;
        else begin
          dy <= dy + YW'(1);
          qy <= qy + QYW'(5);
        end
      end else begin
        dx <= dx + XW'(1);
        qx <= qx + QXW'(5);
      end
    end
  end

  // R4: nearest source pixel always lies inside the previous image
  assert_src_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (sx < {1'b0, src_w}) && (sy < {1'b0, src_h}));

  // R4: writes stay inside the destination image
  assert_dst_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> 32'(wptr) < 32'(dst_w) * 32'(dst_h));
endmodule

// File: rtl/ds_scale_chain.sv
module ds_scale_chain
  import ds_scale_pkg::*;
#(
  parameter int IMG_W = 40,
  parameter int IMG_H = 30,
  parameter int WIN   = 6,
  parameter int PW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [PW-1:0]                in_pixel,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [PW-1:0]                out_pixel,
  output logic                         out_last,
  output logic [$clog2(IMG_W+1)-1:0]   out_width,
  output logic [$clog2(IMG_H+1)-1:0]   out_height,
  output logic [$clog2(IMG_H+1)-1:0]   out_level,
  input  logic                         img_done
);
  localparam int DEPTH = IMG_W * IMG_H;
  localparam int AW    = $clog2(DEPTH);
  localparam int XW    = $clog2(IMG_W + 1);
  localparam int YW    = $clog2(IMG_H + 1);
  localparam int LW    = $clog2(IMG_H + 1);

  ds_state_e     state;
  logic [LW-1:0] lvl;
  logic [XW-1:0] cur_w, nxt_w;
  logic [YW-1:0] cur_h, nxt_h;
  logic          src_sel;
  logic [AW-1:0] lptr, optr;
  logic          out_fin, done_seen;
  logic [AW:0]   npix;
  logic          have_next, load_fire, load_end, out_fire, advance;
  logic          rs_we, rs_fin;
  logic [AW-1:0] rs_src_addr, rs_dst_addr;
  logic [PW-1:0] rd_a [2];
  logic [PW-1:0] rd_b [2];

  assign nxt_w     = XW'(shrink_dim(32'(cur_w)));
  assign nxt_h     = YW'(shrink_dim(32'(cur_h)));
  assign have_next = (nxt_w >= XW'(WIN)) && (nxt_h >= YW'(WIN));
  assign npix      = (AW+1)'(cur_w) * (AW+1)'(cur_h);

  assign in_ready  = (state == ST_LOAD);
  assign load_fire = in_valid && in_ready;
  assign load_end  = load_fire && (lptr == AW'(DEPTH - 1));
  assign out_valid = (state == ST_RUN) && !out_fin;
  assign out_fire  = out_valid && out_ready;
  assign out_last  = out_valid && ({1'b0, optr} == npix - (AW+1)'(1));
  assign advance   = (state == ST_RUN) && out_fin && (done_seen || img_done) && rs_fin;

  assign out_pixel  = rd_a[src_sel];
  assign out_width  = cur_w;
  assign out_height = cur_h;
  assign out_level  = lvl;

  ds_resample #(.XW(XW), .YW(YW), .AW(AW)) u_resample (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load_end || advance),
    .active   ((state == ST_RUN) && have_next),
    .src_w    (cur_w),
    .src_h    (cur_h),
    .dst_w    (nxt_w),
    .dst_h    (nxt_h),
    .we       (rs_we),
    .src_addr (rs_src_addr),
    .dst_addr (rs_dst_addr),
    .fin      (rs_fin)
  );

  // two stores: store 0 also receives the captured frame
  for (genvar b = 0; b < 2; b++) begin : g_store
    logic          st_we;
    logic [AW-1:0] st_waddr;
    logic [PW-1:0] st_wdata;
    logic          take_load;
    assign take_load = (b == 0) ? load_fire : 1'b0;
    assign st_we     = take_load || (rs_we && (src_sel != 1'(b)));
    assign st_waddr  = take_load ? lptr : rs_dst_addr;
    assign st_wdata  = take_load ? in_pixel : rd_b[src_sel];

    ds_pix_mem #(.DEPTH(DEPTH), .PW(PW), .AW(AW)) u_mem (
      .clk     (clk),
      .we      (st_we),
      .waddr   (st_waddr),
      .wdata   (st_wdata),
      .ra_addr (optr),
      .ra_data (rd_a[b]),
      .rb_addr (rs_src_addr),
      .rb_data (rd_b[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_LOAD; lvl <= '0; src_sel <= 1'b0;
      cur_w <= XW'(IMG_W); cur_h <= YW'(IMG_H);
      lptr <= '0; optr <= '0; out_fin <= 1'b0; done_seen <= 1'b0;
    end else if (state == ST_LOAD) begin
      if (load_fire) lptr <= lptr + AW'(1);
      if (load_end) begin
        state <= ST_RUN; lptr <= '0; optr <= '0;
        out_fin <= 1'b0; done_seen <= 1'b0;
      end
    end else begin
      if (out_fire) begin
        optr <= optr + AW'(1);
        if (out_last) out_fin <= 1'b1;
      end
      if (img_done && out_fin) done_seen <= 1'b1;
      if (advance) begin
        optr <= '0; out_fin <= 1'b0; done_seen <= 1'b0;
        if (have_next) begin
          lvl <= lvl + LW'(1); cur_w <= nxt_w; cur_h <= nxt_h; src_sel <= ~src_sel;
        end else begin
          state <= ST_LOAD; lvl <= '0; src_sel <= 1'b0;
          cur_w <= XW'(IMG_W); cur_h <= YW'(IMG_H);
        end
      end
    end
  end

  // R6: a stalled pixel is held
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_pixel) && $stable(out_last));

  // R2: no frame intake while an image plays out
  assert_no_intake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R4: every new level is strictly smaller than the one before
  assert_shrink_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(out_level) && out_level != '0) |->
      (out_height < $past(out_height)) && (out_width < $past(out_width)));

  // R8: no image below the window size is ever played
  assert_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_width >= XW'(WIN)) && (out_height >= YW'(WIN)));
endmodule

// File: tb/ds_scale_chain_test.sv
`timescale 1ns/1ps
module ds_scale_chain_test;
  localparam int W = 20, H = 12, WIN = 4, PW = 8;
  localparam int XW = $clog2(W + 1), YW = $clog2(H + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, img_done = 1'b0;
  logic [PW-1:0] in_pixel = '0;
  logic in_ready, out_valid, out_last;
  logic [PW-1:0] out_pixel;
  logic [XW-1:0] out_width;
  logic [YW-1:0] out_height, out_level;

  always #4 clk = ~clk;

  ds_scale_chain #(.IMG_W(W), .IMG_H(H), .WIN(WIN), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pixel(in_pixel), .out_valid(out_valid), .out_ready(out_ready),
    .out_pixel(out_pixel), .out_last(out_last), .out_width(out_width),
    .out_height(out_height), .out_level(out_level), .img_done(img_done));

  typedef struct { int pix; bit last; bit first; int w; int h; int lv; } exp_t;
  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0, last_seen = 0, rc = 0;
  bit bp_on = 1'b1, hold_pend = 1'b0, hold_last = 1'b0;
  int hold_pix = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // driver: pushes the whole expected chain, then streams the frame in
  task automatic load_and_expect(int seed, output int nlev);
    int img[], nimg[];
    int cw, ch, nw, nh, lv;
    img = new[W * H];
    for (int i = 0; i < W * H; i++) img[i] = ((i % W) * 7 + (i / W) * 13 + seed) & 255;
    cw = W; ch = H; lv = 0;
    forever begin
      for (int i = 0; i < cw * ch; i++) begin
        exp_t e;
        e.pix = img[i]; e.last = (i == cw * ch - 1); e.first = (i == 0);
        e.w = cw; e.h = ch; e.lv = lv;
        exp_q.push_back(e);
      end
      nw = cw * 4 / 5; nh = ch * 4 / 5;
      if (nw < WIN || nh < WIN) break;
      nimg = new[nw * nh];
      for (int y = 0; y < nh; y++)
        for (int x = 0; x < nw; x++)
          nimg[y * nw + x] = img[(y * 5 / 4) * cw + (x * 5 / 4)];
      img = nimg; cw = nw; ch = nh; lv++;
    end
    nlev = lv + 1;
    @(negedge clk);
    for (int i = 0; i < W * H; i++) begin
      in_valid = 1'b1;
      in_pixel = PW'(((i % W) * 7 + (i / W) * 13 + seed) & 255);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // monitor: drives out_ready, pops and compares on every handshake
  initial begin
    forever begin
      @(negedge clk);
      if (hold_pend) begin
        check(out_valid == 1'b1, "R6", "valid held", int'(out_valid), 1);
        check(int'(out_pixel) == hold_pix, "R6", "pixel held", int'(out_pixel), hold_pix);
        check(out_last == hold_last, "R6", "last held", int'(out_last), int'(hold_last));
        hold_pend = 1'b0;
      end
      out_ready = bp_on ? (rc % 5 != 3) : 1'b1;
      rc++;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected pixel", int'(out_pixel), -1);
        end else begin
          exp_t e;
          string rq;
          e = exp_q.pop_front();
          rq = (e.lv == 0) ? "R3" : "R4";
          if (e.first) begin
            check(int'(out_width) == e.w, rq, "width", int'(out_width), e.w);
            check(int'(out_height) == e.h, rq, "height", int'(out_height), e.h);
            check(int'(out_level) == e.lv, rq, "level", int'(out_level), e.lv);
          end
          check(int'(out_pixel) == e.pix, rq, "pixel", int'(out_pixel), e.pix);
          check(out_last == e.last, "R5", "last flag", int'(out_last), int'(e.last));
          if (e.last) last_seen++;
        end
      end else if (out_valid) begin
        hold_pend = 1'b1; hold_pix = int'(out_pixel); hold_last = out_last;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 1, 0);
    summary();
    $finish;
  end

  task automatic run_frame(int seed, bit early_done);
    int nlev;
    last_seen = 0;
    load_and_expect(seed, nlev);
    check(in_ready == 1'b0, "R2", "in_ready after frame", int'(in_ready), 0);
    if (early_done) begin
      repeat (3) @(negedge clk);
      img_done = 1'b1;
      @(negedge clk);
      img_done = 1'b0;
    end
    for (int k = 1; k <= nlev; k++) begin
      wait (last_seen >= k);
      repeat (4) @(negedge clk);
      check(out_valid == 1'b0, "R7", "idle before done", int'(out_valid), 0);
      check(int'(out_level) == k - 1, "R7", "level held", int'(out_level), k - 1);
      img_done = 1'b1;
      @(negedge clk);
      img_done = 1'b0;
      if (k < nlev)
        check(int'(out_level) == k, "R4", "level step", int'(out_level), k);
      else begin
        check(in_ready == 1'b1, "R8", "back to loading", int'(in_ready), 1);
        check(int'(out_level) == 0, "R8", "level cleared", int'(out_level), 0);
      end
    end
    repeat (20) @(negedge clk);
    check(out_valid == 1'b0, "R8", "no extra image", int'(out_valid), 0);
    check(exp_q.size() == 0, "R8", "images left", exp_q.size(), 0);
    check(nlev == 5, "R8", "chain length", nlev, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
    check(out_level == '0, "R1", "out_level", int'(out_level), 0);
    rst_n = 1'b1;
    bp_on = 1'b1;
    run_frame(3, 1'b1);
    bp_on = 1'b0;
    run_frame(91, 1'b0);
    summary();
    $finish;
  end
endmodule